// File: doc/BRIEF.md
# Buffered Paired-Output PWM Generator

This block produces pulse-width modulated waveforms on eight pins arranged as four pairs. A single up-counter, advanced by a selectable prescaled tick, runs from zero to a programmable cycle value and then wraps. Each pair owns a staging register and an active register. Each register holds a compare value and a steering bit that chooses which pin of the pair carries the pulse. The other pin stays at its inactive level for the whole frame. Staged values move into the active registers only at a frame boundary, so software can update them at any time without disturbing the running frame.

Every pin has its own polarity bit and enable bit. A frame-boundary flag latches each wrap and raises an interrupt request when enabled. Software programs the block through a plain write port. There is no back-pressure on this port: a write presented with `wr_en` high is taken at that clock edge, and one register is written per cycle.

Register addresses: 0 control, 1 cycle value, 2 polarity, 3 output enable, 4+p staging register of pair p. Control bits: bit 0 run, bit 1 interrupt enable, bits 4:2 clock select, bit 5 flag (writing 0 clears the flag, writing 1 leaves it unchanged). Staging register: bits 9:0 compare value, bit 10 steering bit.

Top module: `pwm_pair_gen`

## Requirements
- R1: Writing control with bit 0 = 1 while stopped starts the block at that edge. The counter restarts at 0, every staging register is copied into its active register, and the flag is set. Writing bit 0 = 1 while already running has no restart effect.
- R2: While running, the counter steps by one on each tick. When it equals the cycle value, the next tick returns it to 0, so a frame lasts cycle value + 1 ticks.
- R3: At every wrap, all four staging registers are copied to their active registers together. A staging write between wraps leaves the running waveform unchanged.
- R4: The pin of pair p chosen by its steering bit (0 selects pin 2p, 1 selects pin 2p+1) is high while the counter is below the active compare value. The partner pin stays low for the whole frame. A compare value of 0 gives no pulse, and a value above the cycle value gives a pulse that fills the frame.
- R5: A polarity bit of 1 inverts the level of that pin.
- R6: A pin whose enable bit is 0 outputs 0. All enables are 0 after reset.
- R7: A start or a wrap sets the flag, and this setting wins over a clear in the same cycle. A control write with bit 5 = 0 clears the flag. The interrupt request is the flag ANDed with the interrupt-enable bit.
- R8: Clock select n gives one tick every 2^n clocks, for n from 0 to 7. The prescaler restarts on a start.
- R9: Writing control with bit 0 = 0 stops the block. From the next cycle the counter is held at 0, and every enabled pin shows its inactive level (its polarity bit).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address |
| wr_data | input | 11 | Register write data |
| pwm_o | output | 8 | PWM pins, pair p on bits 2p and 2p+1 |
| irq_o | output | 1 | Interrupt request |

## Verification
On every cycle, the assertions check the counter step and wrap rules and the idle hold of the counter. They also check that the active registers change only at a load and then take the staged values, that a load always leaves the flag set, that a clear without a load drops it, and the tick spacing of the prescaler. Pulse widths, pair steering, polarity and enable masking, the fact that a mid-frame staging write is ignored until the boundary, and the slow prescale ratios can only be shown by the bench's scenarios. There, a behavioural model predicts every pin and the interrupt on each clock.

// File: rtl/pwm_pair_pkg.sv
package pwm_pair_pkg;
  localparam int CKS_W    = 3;
  localparam int BIT_RUN  = 0;
  localparam int BIT_IE   = 1;
  localparam int BIT_CKS  = 2;
  localparam int BIT_FLAG = BIT_CKS + CKS_W;
  localparam int ADR_CTRL  = 0;
  localparam int ADR_CYCLE = 1;
  localparam int ADR_POL   = 2;
  localparam int ADR_OE    = 3;
  localparam int ADR_STAGE = 4;
endpackage

// File: rtl/pwm_prescaler.sv
module pwm_prescaler #(
  parameter int SEL_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [SEL_W-1:0] sel,
  output logic             tick
);
  localparam int PRE_W = (1 << SEL_W) - 1;

  logic [PRE_W-1:0] pre_q;
  logic [PRE_W-1:0] mask;

  always_comb begin
    mask = PRE_W'((32'd1 << sel) - 32'd1);
    tick = run && ((pre_q & mask) == mask);
  end

  always_ff @(posedge clk) begin
    if (!rst_n)   pre_q <= '0;
    else if (!run) pre_q <= '0;
    else          pre_q <= pre_q + 1'b1;
  end

  // R8: with a divide above 1, two ticks are never adjacent
  a_r8_tick_gap: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && sel != '0) |=> (!tick || $changed(sel)));
endmodule

// File: rtl/pwm_timebase.sv
module pwm_timebase #(
  parameter int CNT_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             start,
  input  logic             tick,
  input  logic [CNT_W-1:0] cycle_val,
  output logic [CNT_W-1:0] cnt,
  output logic             wrap,
  output logic             load
);
  logic [CNT_W-1:0] cnt_q;

  assign cnt  = cnt_q;
  assign wrap = run && tick && (cnt_q == cycle_val);
  assign load = start || wrap;

  always_ff @(posedge clk) begin
    if (!rst_n)         cnt_q <= '0;
    else if (start)     cnt_q <= '0;
    else if (!run)      cnt_q <= '0;
    else if (tick)      cnt_q <= wrap ? '0 : cnt_q + 1'b1;
  end

  a_r2_wrap_zero: assert property (@(posedge clk) disable iff (!rst_n)
    wrap |=> (cnt_q == '0));
  a_r2_step: assert property (@(posedge clk) disable iff (!rst_n)
    (run && tick && !wrap && !start) |=> (cnt_q == CNT_W'($past(cnt_q) + 1'b1)));
  a_r9_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !start) |=> (cnt_q == '0));
endmodule

// File: rtl/pwm_pair.sv
module pwm_pair #(
  parameter int CNT_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             stage_we,
  input  logic [CNT_W-1:0] stage_cmp,
  input  logic             stage_sel,
  input  logic             load,
  input  logic             run,
  input  logic [CNT_W-1:0] cnt,
  output logic [1:0]       raw
);
  logic [CNT_W-1:0] stg_cmp_q, act_cmp_q;
  logic             stg_sel_q, act_sel_q;
  logic             on;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stg_cmp_q <= '0;
      stg_sel_q <= 1'b0;
      act_cmp_q <= '0;
      act_sel_q <= 1'b0;
    end else begin
      if (stage_we) begin
        stg_cmp_q <= stage_cmp;
        stg_sel_q <= stage_sel;
      end
      if (load) begin
        act_cmp_q <= stg_cmp_q;
        act_sel_q <= stg_sel_q;
      end
    end
  end

  assign on     = run && (cnt < act_cmp_q);
  assign raw[0] = on && !act_sel_q;
  assign raw[1] = on && act_sel_q;

  a_r3_load: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (act_cmp_q == $past(stg_cmp_q) && act_sel_q == $past(stg_sel_q)));
  a_r3_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> ($stable(act_cmp_q) && $stable(act_sel_q)));
endmodule

// File: rtl/pwm_pair_gen.sv
module pwm_pair_gen
  import pwm_pair_pkg::*;
#(
  parameter int CNT_W  = 10,
  parameter int NPAIR  = 4,
  parameter int ADDR_W = 3,
  localparam int NPIN  = 2 * NPAIR,
  localparam int DW0   = (CNT_W + 1 > NPIN) ? CNT_W + 1 : NPIN,
  localparam int DATA_W = (DW0 > BIT_FLAG + 1) ? DW0 : BIT_FLAG + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic [NPIN-1:0]   pwm_o,
  output logic              irq_o
);
  logic             run_q, ie_q, flag_q;
  logic [CKS_W-1:0] cks_q;
  logic [CNT_W-1:0] cycle_q;
  logic [NPIN-1:0]  pol_q, oe_q, raw;
  logic             ctrl_wr, start, tick, wrap, load;
  logic [CNT_W-1:0] cnt;

  assign ctrl_wr = wr_en && (wr_addr == ADDR_W'(ADR_CTRL));
  assign start   = ctrl_wr && wr_data[BIT_RUN] && !run_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run_q   <= 1'b0;
      ie_q    <= 1'b0;
      cks_q   <= '0;
      flag_q  <= 1'b0;
      cycle_q <= '0;
      pol_q   <= '0;
      oe_q    <= '0;
    end else begin
      if (ctrl_wr) begin
        run_q <= wr_data[BIT_RUN];
        ie_q  <= wr_data[BIT_IE];
        cks_q <= wr_data[BIT_CKS +: CKS_W];
      end
      if (load)                             flag_q <= 1'b1;
      else if (ctrl_wr && !wr_data[BIT_FLAG]) flag_q <= 1'b0;
      if (wr_en && wr_addr == ADDR_W'(ADR_CYCLE)) cycle_q <= wr_data[CNT_W-1:0];
      if (wr_en && wr_addr == ADDR_W'(ADR_POL))   pol_q   <= wr_data[NPIN-1:0];
      if (wr_en && wr_addr == ADDR_W'(ADR_OE))    oe_q    <= wr_data[NPIN-1:0];
    end
  end

  pwm_prescaler #(.SEL_W(CKS_W)) i_presc (
    .clk(clk), .rst_n(rst_n), .run(run_q), .sel(cks_q), .tick(tick)
  );

  pwm_timebase #(.CNT_W(CNT_W)) i_tb (
    .clk(clk), .rst_n(rst_n), .run(run_q), .start(start), .tick(tick),
    .cycle_val(cycle_q), .cnt(cnt), .wrap(wrap), .load(load)
  );

  for (genvar p = 0; p < NPAIR; p++) begin : g_pair
    logic we;
    assign we = wr_en && (wr_addr == ADDR_W'(ADR_STAGE + p));
    pwm_pair #(.CNT_W(CNT_W)) i_pair (
      .clk(clk), .rst_n(rst_n), .stage_we(we),
      .stage_cmp(wr_data[CNT_W-1:0]), .stage_sel(wr_data[CNT_W]),
      .load(load), .run(run_q), .cnt(cnt), .raw(raw[2*p +: 2])
    );
  end

  for (genvar i = 0; i < NPIN; i++) begin : g_pin
    assign pwm_o[i] = oe_q[i] && (raw[i] ^ pol_q[i]);
  end

  assign irq_o = flag_q && ie_q;

  a_r7_flag_set: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> flag_q);
  a_r7_flag_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_wr && !wr_data[BIT_FLAG] && !load) |=> !flag_q);
  a_r1_start_runs: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (run_q && cnt == '0));
endmodule

// File: tb/test_pwm_pair_gen.sv
`timescale 1ns/1ps
module test_pwm_pair_gen;
  logic        clk = 0, rst_n = 0, wr_en = 0;
  logic [2:0]  wr_addr = 0;
  logic [10:0] wr_data = 0;
  logic [7:0]  pwm_o;
  logic        irq_o;

  pwm_pair_gen i_pwm_pair_gen (.clk(clk), .rst_n(rst_n), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .pwm_o(pwm_o), .irq_o(irq_o));

  always #2 clk = ~clk;

  int total = 0, bad = 0, cycles = 0;
  bit done = 0;

  // behavioural reference model
  int m_run, m_ie, m_cks, m_flag, m_cyc, m_pol, m_oe, m_cnt, m_pre;
  int m_stg[4], m_ssel[4], m_act[4], m_asel[4];
  int mask; bit tick, wrp, st, cw;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_run = 0; m_ie = 0; m_cks = 0; m_flag = 0; m_cyc = 0; m_pol = 0;
      m_oe = 0; m_cnt = 0; m_pre = 0;
      for (int p = 0; p < 4; p++) begin m_stg[p] = 0; m_ssel[p] = 0; m_act[p] = 0; m_asel[p] = 0; end
    end else begin
      mask = (1 << m_cks) - 1;
      tick = m_run != 0 && ((m_pre & mask) == mask);
      wrp  = tick && m_cnt == m_cyc;
      cw   = wr_en && wr_addr == 0;
      st   = cw && wr_data[0] && m_run == 0;
      if (cw && !wr_data[5]) m_flag = 0;
      if (st || wrp) begin
        for (int p = 0; p < 4; p++) begin m_act[p] = m_stg[p]; m_asel[p] = m_ssel[p]; end
        m_flag = 1;
      end
      if (st) begin m_cnt = 0; m_pre = 0; end
      else if (m_run != 0) begin
        m_pre = (m_pre + 1) % 128;
        if (tick) m_cnt = wrp ? 0 : (m_cnt + 1) % 1024;
      end else begin m_cnt = 0; m_pre = 0; end
      if (wr_en) begin
        case (wr_addr)
          0: begin m_run = wr_data[0]; m_ie = wr_data[1]; m_cks = wr_data[4:2]; end
          1: m_cyc = wr_data[9:0];
          2: m_pol = wr_data[7:0];
          3: m_oe  = wr_data[7:0];
          default: begin m_stg[wr_addr-4] = wr_data[9:0]; m_ssel[wr_addr-4] = wr_data[10]; end
        endcase
      end
    end
  end

  function automatic logic [7:0] model_pins();
    logic [7:0] r;
    for (int p = 0; p < 4; p++) begin
      bit on; bit lv0, lv1;
      on  = m_run != 0 && m_cnt < m_act[p];
      lv0 = on && m_asel[p] == 0;
      lv1 = on && m_asel[p] != 0;
      r[2*p]   = m_oe[2*p]   && (lv0 ^ m_pol[2*p]);
      r[2*p+1] = m_oe[2*p+1] && (lv1 ^ m_pol[2*p+1]);
    end
    return r;
  endfunction

  task automatic check(bit ok, string tag, int act, int exp);
    total++;
    if (!ok) begin bad++; $display("FAIL %s actual=%0h expected=%0h", tag, act, exp); end
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) begin
      logic [7:0] e;
      e = model_pins();
      check(pwm_o == e, "R2 R3 R4 R5 R6 R8 R9 pins", pwm_o, e);
      check(irq_o == (m_flag != 0 && m_ie != 0), "R7 irq", irq_o, (m_flag != 0 && m_ie != 0));
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !done) begin
      done = 1; total++; bad++;
      $display("FAIL watchdog actual=%0d expected=<150000", cycles);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic wr(int a, int d);
    @(negedge clk); wr_en = 1; wr_addr = a[2:0]; wr_data = d[10:0];
    @(negedge clk); wr_en = 0;
  endtask

  task automatic count_high(int pin, int n, output int hits);
    hits = 0;
    for (int k = 0; k < n; k++) begin @(negedge clk); if (pwm_o[pin]) hits++; end
  endtask

  initial begin
    int h;
    repeat (4) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check(pwm_o == 0, "R6 reset pins", pwm_o, 0);
    check(irq_o == 0, "R7 reset irq", irq_o, 0);
    // setup: cycle 9, pair0 3/sel0, pair1 5/sel1, pair2 0, pair3 12/sel0
    wr(1, 9); wr(2, 0); wr(3, 8'hFF);
    wr(4, 3); wr(5, 5 | 1024); wr(6, 0); wr(7, 12);
    wr(0, 32'h3);                       // R1 start, irq enabled, divide 1
    check(pwm_o[0] == 1 && pwm_o[1] == 0, "R1 start pulse", pwm_o, 1);
    repeat (12) @(negedge clk);
    count_high(0, 10, h); check(h == 3, "R4 pin0 width", h, 3);
    count_high(1, 10, h); check(h == 0, "R4 partner low", h, 0);
    count_high(3, 10, h); check(h == 5, "R4 steered pin3", h, 5);
    count_high(4, 10, h); check(h == 0, "R4 zero compare", h, 0);
    count_high(6, 10, h); check(h == 10, "R4 full frame", h, 10);
    // R3 mid-frame staging change, then flag clear R7
    repeat (3) @(negedge clk);
    wr(4, 7 | 1024);
    repeat (25) @(negedge clk);
    count_high(1, 10, h); check(h == 7, "R3 new value after wrap", h, 7);
    wr(0, 32'h3);                       // clear flag, R1 no restart
    repeat (20) @(negedge clk);
    // R5 polarity and R6 enable
    wr(2, 8'h0F); wr(3, 8'h3C);
    repeat (30) @(negedge clk);
    // R8 prescale: divide 4 then divide 128
    wr(0, (2 << 2) | 1 | 2);
    repeat (100) @(negedge clk);
    wr(1, 3); wr(5, 1); wr(0, (7 << 2) | 1 | 2);
    repeat (1100) @(negedge clk);
    // R9 stop
    wr(0, 0);
    check(pwm_o == 8'h0C, "R9 stopped pins", pwm_o, 8'h0C);
    repeat (10) @(negedge clk);
    // R1 restart with new staging
    wr(2, 0); wr(3, 8'hFF); wr(4, 2 | 1024);
    wr(0, 1);
    check(pwm_o[1] == 1 && pwm_o[0] == 0, "R1 restart steering", pwm_o, 2);
    repeat (40) @(negedge clk);
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule